// File: doc/BRIEF.md
# Cycle-Counter Interrupt Timer

This block is a free-running 15-bit up-counter that advances once per CPU cycle and raises an interrupt request when it climbs to its top value. Software reaches the live count itself, not a reload copy, through two byte-wide registers. The low register holds the lower eight count bits. The high register holds the upper seven count bits and the run/interrupt enable bit.

Software normally writes a start value with the enable bit set. It then waits for the request and acknowledges it by touching either register. After the counter reaches its top value it stays there until software loads a new count. Both registers stay live while the counter runs, so a read always returns the current count.

Top module: `cyc_irq_timer`

## Requirements
- R1: After reset the count is 0x0000, the enable bit is 0 and `irq` is 0, so both registers read 0x00.
- R2: `rd_data` always shows the register picked by `sel_hi`. With `sel_hi`=0 it shows count bits 7:0. With `sel_hi`=1 it shows the enable bit in bit 7 and count bits 14:8 in bits 6:0. `rd_en` only marks an access and does not affect `rd_data`.
- R3: A write with `sel_hi`=0 loads count bits 7:0 from `wr_data` and leaves the rest unchanged. A write with `sel_hi`=1 loads count bits 14:8 from `wr_data[6:0]` and the enable bit from `wr_data[7]`. The new value is visible after the clock edge.
- R4: While the enable bit is 1, the count rises by exactly one on each clock edge where `cyc_en` is 1. Edges where `cyc_en` is 0 leave it unchanged.
- R5: While the enable bit is 0, the count does not change, whatever `cyc_en` does.
- R6: Once the count is 0x7FFF it stays at 0x7FFF on further enabled cycles and does not wrap.
- R7: `irq` rises on the edge where the count steps from 0x7FFE to 0x7FFF, and it stays high until acknowledged. Loading 0x7FFF by a write does not raise it.
- R8: A read or a write of either register clears `irq` on the next edge. The request does not return while the count just sits at 0x7FFF.
- R9: A write in the same cycle as an increment takes priority. The written byte takes the written value, and the other byte keeps its present value with no increment or carry.
- R10: If the step into 0x7FFF and a read fall in the same cycle, `irq` is set and not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_en | input | 1 | One-clock strobe per CPU cycle |
| sel_hi | input | 1 | Register select: 0 low byte, 1 high byte with enable |
| rd_en | input | 1 | Read access to the selected register |
| wr_en | input | 1 | Write access to the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Contents of the selected register |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest cases to reach are collisions in a single cycle. One is an access landing on the exact edge where the count steps into 0x7FFF. The other is a write landing on an edge where the counter would otherwise increment. The bench loads 0x7FFD or similar values, counts the strobes up to the cycle just before the step, and then asserts the access and `cyc_en` together. Long runs are avoided by preloading counts near the boundaries, including a carry from the low byte into the high byte.

// File: rtl/cyc_irq_pkg.sv
package cyc_irq_pkg;

    typedef enum logic {
        SEL_LO = 1'b0,
        SEL_HI = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/cyc_irq_count.sv
module cyc_irq_count #(
    parameter int CNT_W  = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  cnt,
    output logic              en,
    output logic              step_max
);
    localparam int HI_W = CNT_W - DATA_W;
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] PRE = TOP - CNT_W'(1);

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       step;

    always_comb begin
        st_d = st_q;
        step = st_q.en && cyc_en && !wr_lo && !wr_hi && (st_q.cnt != TOP);
        if (step) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        if (wr_lo) begin
            st_d.cnt[DATA_W-1:0] = wr_data;
        end
        if (wr_hi) begin
            st_d.cnt[CNT_W-1:DATA_W] = wr_data[HI_W-1:0];
            st_d.en                  = wr_data[DATA_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt      = st_q.cnt;
    assign en       = st_q.en;
    assign step_max = step && (st_q.cnt == PRE);

endmodule

// File: rtl/cyc_irq_flag.sv
module cyc_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic step_max,
    input  logic access,
    output logic irq
);
    typedef struct packed {
        logic pend;
    } flag_state_t;

    flag_state_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (access) begin
            fl_d.pend = 1'b0;
        end
        if (step_max) begin
            fl_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign irq = fl_q.pend;

endmodule

// File: rtl/cyc_irq_rdmux.sv
module cyc_irq_rdmux
    import cyc_irq_pkg::*;
#(
    parameter int CNT_W  = 15,
    parameter int DATA_W = 8
) (
    input  logic              sel_hi,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              en,
    output logic [DATA_W-1:0] rd_data
);
    localparam int HI_W  = CNT_W - DATA_W;
    localparam int PAD_W = DATA_W - 1 - HI_W;

    logic [DATA_W-1:0] hi_byte;

    generate
        if (PAD_W > 0) begin : g_pad
            assign hi_byte = {en, {PAD_W{1'b0}}, cnt[CNT_W-1:DATA_W]};
        end else begin : g_nopad
            assign hi_byte = {en, cnt[CNT_W-1:DATA_W]};
        end
    endgenerate

    always_comb begin
        unique case (reg_sel_e'(sel_hi))
            SEL_HI:  rd_data = hi_byte;
            default: rd_data = cnt[DATA_W-1:0];
        endcase
    end

endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer #(
    parameter int CNT_W  = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic              sel_hi,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic [CNT_W-1:0] cnt_w;
    logic             en_w;
    logic             step_max_w;
    logic             wr_lo_w;
    logic             wr_hi_w;
    logic             access_w;

    assign wr_lo_w  = wr_en && !sel_hi;
    assign wr_hi_w  = wr_en && sel_hi;
    assign access_w = rd_en || wr_en;

    cyc_irq_count #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_en   (cyc_en),
        .wr_lo    (wr_lo_w),
        .wr_hi    (wr_hi_w),
        .wr_data  (wr_data),
        .cnt      (cnt_w),
        .en       (en_w),
        .step_max (step_max_w)
    );

    cyc_irq_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_max (step_max_w),
        .access   (access_w),
        .irq      (irq)
    );

    cyc_irq_rdmux #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_rdmux (
        .sel_hi  (sel_hi),
        .cnt     (cnt_w),
        .en      (en_w),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/cyc_irq_checker.sv
module cyc_irq_checker #(
    parameter int CNT_W  = 15,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_en,
    input logic              sel_hi,
    input logic              rd_en,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [CNT_W-1:0]  cnt,
    input logic              en,
    input logic              irq
);
    localparam int HI_W = CNT_W - DATA_W;
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] PRE = TOP - CNT_W'(1);

    logic into_top;
    assign into_top = en && cyc_en && !wr_en && (cnt == PRE);

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cyc_en && !wr_en && cnt != TOP) |=> cnt == $past(cnt) + CNT_W'(1)); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_en && !wr_en) |=> $stable(cnt)); // R4
    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_en) |=> $stable(cnt)); // R5
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == TOP && !wr_en) |=> cnt == TOP); // R6
    AST_IRQ_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        into_top |=> irq); // R7
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(into_top)); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && !into_top) |=> !irq); // R8
    AST_WRITE_LO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel_hi) |=> (cnt[DATA_W-1:0] == $past(wr_data)
                                && cnt[CNT_W-1:DATA_W] == $past(cnt[CNT_W-1:DATA_W]))); // R9
    AST_WRITE_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_hi) |=> (en == $past(wr_data[DATA_W-1])
                               && cnt[CNT_W-1:DATA_W] == $past(wr_data[HI_W-1:0])
                               && cnt[DATA_W-1:0] == $past(cnt[DATA_W-1:0]))); // R3
    AST_STEP_BEATS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (into_top && rd_en) |=> irq); // R10

endmodule

bind cyc_irq_timer cyc_irq_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cyc_en  (cyc_en),
    .sel_hi  (sel_hi),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cnt     (cnt_w),
    .en      (en_w),
    .irq     (irq)
);

// File: tb/cyc_irq_timer_tb.sv
module cyc_irq_timer_tb;
    localparam int CLK_P = 10;
    localparam int NVEC  = 9;

    // entry: start hi, start lo, strobes, expected hi, expected lo, expected irq
    localparam logic [44:0] VEC [NVEC] = '{
        {8'h80, 8'h00, 12'd5,   8'h80, 8'h05, 1'b0},
        {8'h80, 8'hFF, 12'd1,   8'h81, 8'h00, 1'b0},
        {8'h00, 8'h10, 12'd7,   8'h00, 8'h10, 1'b0},
        {8'hFF, 8'hFA, 12'd4,   8'hFF, 8'hFE, 1'b0},
        {8'hFF, 8'hFA, 12'd5,   8'hFF, 8'hFF, 1'b1},
        {8'hFF, 8'hFA, 12'd9,   8'hFF, 8'hFF, 1'b1},
        {8'hFF, 8'hFF, 12'd3,   8'hFF, 8'hFF, 1'b0},
        {8'h7F, 8'hFE, 12'd3,   8'h7F, 8'hFE, 1'b0},
        {8'hC2, 8'h34, 12'd256, 8'hC3, 8'h34, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b0;
    logic       sel_hi = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq;

    int total = 0;
    int bad   = 0;
    logic [7:0] pk_lo, pk_hi;

    always #(CLK_P/2) clk = ~clk;

    cyc_irq_timer u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .sel_hi(sel_hi),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic hi, input logic [7:0] d);
        @(negedge clk);
        sel_hi = hi; wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic hi);
        @(negedge clk);
        sel_hi = hi; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic run(input int n);
        cyc_en = 1'b1;
        repeat (n) @(negedge clk);
        cyc_en = 1'b0;
    endtask

    task automatic peek();
        sel_hi = 1'b0; #1; pk_lo = rd_data;
        sel_hi = 1'b1; #1; pk_hi = rd_data;
    endtask

    initial begin
        #(CLK_P * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        peek();
        chk("R1 reset count", {pk_hi, pk_lo}, 16'h0000);
        chk("R1 reset irq", {15'd0, irq}, 16'd0);
        rst_n = 1'b1;

        // table walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            do_wr(1'b1, VEC[i][44:37]);
            do_wr(1'b0, VEC[i][36:29]);
            run(int'(VEC[i][28:17]));
            peek();
            chk("R4/R5/R6 count vec", {pk_hi, pk_lo}, VEC[i][16:1]);
            chk("R7 irq vec", {15'd0, irq}, {15'd0, VEC[i][0]});
        end

        // R4: strobe low leaves count alone
        do_wr(1'b1, 8'h80);
        do_wr(1'b0, 8'h20);
        repeat (5) @(negedge clk);
        peek();
        chk("R4 no strobe", {pk_hi, pk_lo}, 16'h8020);

        // R8: read of low register acknowledges, no re-raise while held at top
        do_wr(1'b1, 8'hFF);
        do_wr(1'b0, 8'hFD);
        run(2);
        chk("R7 raised", {15'd0, irq}, 16'd1);
        do_rd(1'b0);
        chk("R8 read lo ack", {15'd0, irq}, 16'd0);
        run(3);
        peek();
        chk("R8 no re-raise", {15'd0, irq}, 16'd0);
        chk("R6 held top", {pk_hi, pk_lo}, 16'hFFFF);

        // R8: read of high register acknowledges
        do_wr(1'b0, 8'hFE);
        run(1);
        chk("R7 raised again", {15'd0, irq}, 16'd1);
        do_rd(1'b1);
        chk("R8 read hi ack", {15'd0, irq}, 16'd0);

        // R9: write beats increment, low and high
        do_wr(1'b1, 8'h80);
        do_wr(1'b0, 8'h10);
        sel_hi = 1'b0; wr_en = 1'b1; wr_data = 8'h55; cyc_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; cyc_en = 1'b0;
        peek();
        chk("R9 lo write wins", {pk_hi, pk_lo}, 16'h8055);
        do_wr(1'b0, 8'hFF);
        sel_hi = 1'b1; wr_en = 1'b1; wr_data = 8'h85; cyc_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; cyc_en = 1'b0;
        peek();
        chk("R9 hi write wins", {pk_hi, pk_lo}, 16'h85FF);

        // R10: step into top together with a read
        do_wr(1'b1, 8'hFF);
        do_wr(1'b0, 8'hFD);
        run(1);
        sel_hi = 1'b0; rd_en = 1'b1; cyc_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; cyc_en = 1'b0;
        peek();
        chk("R10 set beats read", {15'd0, irq}, 16'd1);
        chk("R10 count top", {pk_hi, pk_lo}, 16'hFFFF);

        // R1: reset in the middle of operation
        rst_n = 1'b0;
        #1;
        peek();
        chk("R1 mid reset count", {pk_hi, pk_lo}, 16'h0000);
        chk("R1 mid reset irq", {15'd0, irq}, 16'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule